// File: doc/BRIEF.md
# Per-Port Bandwidth Demand Estimator

This unit sits at one input port of a rate-scheduled switch. Once per regulation period of a fixed number of slots it produces, for every output flow of the port, an integer demand that a central allocator uses when it grants bandwidth for the period after next. The allocator answers one period late, so the demand covers that lag. It adds two terms:

- An exponentially weighted forecast of arrivals, with weight one half on the newest sample.
- A forecast of the queue backlog at the start of the next period. This is the current backlog, plus the cells that arrived in the period just ended, minus the cells the current allocation allowed out.

The unit counts per-flow arrivals itself, one cell per slot at most. At each period boundary it freezes the counts, backlogs and allocations. It then updates the flows one per clock in a single shared datapath and raises a one-cycle completion strobe.

Top module: `demand_estimator`

## Requirements
- R1: While reset is held, every demand output is 0 and the completion strobe is 0. Every forecast restarts from 0 after reset.
- R2: A cell counts for flow `arr_flow` only in a clock where `slot_en` and `arr_valid` are both 1. A cell presented while `slot_en` is 0 changes no demand.
- R3: A period boundary occurs on every `PERIOD_SLOTS`-th clock with `slot_en` = 1. A cell in that last slot counts toward the period that is ending. Clocks with `slot_en` = 0 do not advance the period.
- R4: At each boundary, each flow's arrival forecast becomes floor((count of the ending period + previous forecast) / 2).
- R5: The backlog forecast is backlog + count − allocation, using the `backlog_flat` and `alloc_flat` values present in the boundary slot. A negative result is clamped to 0.
- R6: A flow's demand is the arrival forecast plus the backlog forecast, saturated at 2^CNT_W − 1. Flow i occupies bits [i*CNT_W +: CNT_W] of each flat bus.
- R7: Flow i's demand output changes at the (i+1)-th clock edge after the boundary edge. Between those updates it holds, whatever `backlog_flat` and `alloc_flat` do.
- R8: `sweep_done` is 1 for exactly one clock. That clock is the one right after the edge that writes the last flow's demand, once per period. The block assumes `PERIOD_SLOTS` ≥ `N_FLOWS` + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | 1 | Marks a clock as one cell slot |
| arr_valid | input | 1 | A cell arrives in this slot |
| arr_flow | input | FW | Output flow of the arriving cell |
| backlog_flat | input | N_FLOWS*CNT_W | Current per-flow queue backlog |
| alloc_flat | input | N_FLOWS*CNT_W | Cells granted per flow for the current period |
| demand_flat | output | N_FLOWS*CNT_W | Per-flow demand for the next period |
| sweep_done | output | 1 | One-cycle strobe: all demands updated |

## Verification
The first pattern is a mixed arrival stream in which `slot_en` gaps carry a valid cell. It separates the correct slot gating from designs that count every valid cell or advance the period on idle clocks. A steady single-flow stream held over many periods shows the halving forecast converging, and it exposes any rounding or weighting error. Large allocations that drive the backlog term negative test the clamp, and a full-scale backlog tests the saturation. Last, the backlog and allocation inputs are changed on every clock. This shows that only boundary-slot values are used and that the demands move only on their own sweep edges.

// File: rtl/demand_pkg.sv
// Shared types for the demand estimator.
package demand_pkg;
    // Sweep controller state: idle between periods, running while flows are updated.
    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_t;
endpackage

// File: rtl/slot_timer.sv
// Slot timer: counts enabled slots and flags the last slot of each period.
// Assumes PERIOD_SLOTS >= 2. The boundary flag is combinational from the
// registered count and slot_en.
module slot_timer #(
    parameter int PERIOD_SLOTS = 16,
    localparam int PW = (PERIOD_SLOTS > 1) ? $clog2(PERIOD_SLOTS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_en,
    output logic boundary
);
    logic [PW-1:0] slot_q;

    // Last slot of the period is being consumed now.
    assign boundary = slot_en && (slot_q == PW'(PERIOD_SLOTS - 1));

    // Slot position within the period.
    always_ff @(posedge clk) begin
        if (!rst_n)        slot_q <= '0;
        else if (boundary) slot_q <= '0;
        else if (slot_en)  slot_q <= slot_q + 1'b1;
    end
endmodule

// File: rtl/arrival_counter.sv
// Per-flow arrival counters for the running period.
// cnt_incl is each count including a cell in the current slot. The counters
// clear at the boundary. Assumes PERIOD_SLOTS fits in CNT_W, so no wrap.
module arrival_counter #(
    parameter int N_FLOWS = 4,
    parameter int CNT_W   = 16,
    localparam int FW = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slot_en,
    input  logic                     arr_valid,
    input  logic [FW-1:0]            arr_flow,
    input  logic                     boundary,
    output logic [N_FLOWS*CNT_W-1:0] cnt_incl
);
    for (genvar g = 0; g < N_FLOWS; g++) begin : g_flow
        logic [CNT_W-1:0] cnt_q;
        logic             hit;

        // This slot carries a cell for flow g.
        assign hit = slot_en && arr_valid && (arr_flow == FW'(g));
        // Count seen so far, including the present slot.
        assign cnt_incl[g*CNT_W +: CNT_W] = cnt_q + CNT_W'(hit);

        // Accumulate arrivals; restart at the period boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)        cnt_q <= '0;
            else if (boundary) cnt_q <= '0;
            else if (hit)      cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/demand_calc.sv
// Combinational demand arithmetic for one flow.
// Forecast = floor((arr + pred_old)/2). Backlog term = max(0, bkl + arr - alc).
// Demand = forecast + backlog term, saturated to CNT_W bits.
module demand_calc #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] arr,
    input  logic [CNT_W-1:0] pred_old,
    input  logic [CNT_W-1:0] bkl,
    input  logic [CNT_W-1:0] alc,
    output logic [CNT_W-1:0] pred_new,
    output logic [CNT_W-1:0] dem
);
    logic [CNT_W:0]   avg_sum;
    logic [CNT_W:0]   inflow;
    logic [CNT_W:0]   bkl_fc;
    logic [CNT_W+1:0] total;

    // Exponential average with weight one half.
    assign avg_sum  = {1'b0, arr} + {1'b0, pred_old};
    assign pred_new = avg_sum[CNT_W:1];

    // Backlog forecast, clamped at zero.
    assign inflow = {1'b0, bkl} + {1'b0, arr};
    assign bkl_fc = (inflow > {1'b0, alc}) ? (inflow - {1'b0, alc}) : '0;

    // Sum and saturate to the counter width.
    assign total = {1'b0, bkl_fc} + {2'b00, pred_new};
    assign dem   = (total[CNT_W+1:CNT_W] != 2'b00) ? '1 : total[CNT_W-1:0];
endmodule

// File: rtl/demand_estimator.sv
// Top: per-port bandwidth demand estimator.
// Freezes arrivals, backlogs and allocations at each period boundary, then
// sweeps the flows one per clock through one shared demand_calc.
// Assumes PERIOD_SLOTS >= N_FLOWS + 1 so that a sweep ends before the next
// boundary. A boundary that arrives early restarts the sweep.
module demand_estimator #(
    parameter int N_FLOWS      = 4,
    parameter int CNT_W        = 16,
    parameter int PERIOD_SLOTS = 16,
    localparam int FW = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1,
    localparam int VW = N_FLOWS * CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_en,
    input  logic          arr_valid,
    input  logic [FW-1:0] arr_flow,
    input  logic [VW-1:0] backlog_flat,
    input  logic [VW-1:0] alloc_flat,
    output logic [VW-1:0] demand_flat,
    output logic          sweep_done
);
    import demand_pkg::*;

    logic                boundary;
    logic [VW-1:0]       cnt_incl;
    sweep_state_t        state;
    logic [FW-1:0]       idx;
    logic                running;
    logic                done_q;
    logic [CNT_W-1:0]    arr_snap [N_FLOWS];
    logic [CNT_W-1:0]    bkl_snap [N_FLOWS];
    logic [CNT_W-1:0]    alc_snap [N_FLOWS];
    logic [CNT_W-1:0]    pred_q   [N_FLOWS];
    logic [CNT_W-1:0]    dem_q    [N_FLOWS];
    logic [CNT_W-1:0]    pred_new;
    logic [CNT_W-1:0]    dem_new;

    slot_timer #(.PERIOD_SLOTS(PERIOD_SLOTS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_en  (slot_en),
        .boundary (boundary)
    );

    arrival_counter #(.N_FLOWS(N_FLOWS), .CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .arr_valid (arr_valid),
        .arr_flow  (arr_flow),
        .boundary  (boundary),
        .cnt_incl  (cnt_incl)
    );

    demand_calc #(.CNT_W(CNT_W)) u_calc (
        .arr      (arr_snap[idx]),
        .pred_old (pred_q[idx]),
        .bkl      (bkl_snap[idx]),
        .alc      (alc_snap[idx]),
        .pred_new (pred_new),
        .dem      (dem_new)
    );

    assign running    = (state == SW_RUN);
    assign sweep_done = done_q;

    // Sweep controller: start at a boundary, step one flow per clock, strobe at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SW_IDLE;
            idx    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (boundary) begin
                state <= SW_RUN;
                idx   <= '0;
            end else if (running) begin
                if (idx == FW'(N_FLOWS - 1)) begin
                    state  <= SW_IDLE;
                    idx    <= '0;
                    done_q <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < N_FLOWS; g++) begin : g_flow
        logic wr;
        assign wr = running && (idx == FW'(g));

        // Freeze this flow's inputs in the boundary slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                arr_snap[g] <= '0;
                bkl_snap[g] <= '0;
                alc_snap[g] <= '0;
            end else if (boundary) begin
                arr_snap[g] <= cnt_incl[g*CNT_W +: CNT_W];
                bkl_snap[g] <= backlog_flat[g*CNT_W +: CNT_W];
                alc_snap[g] <= alloc_flat[g*CNT_W +: CNT_W];
            end
        end

        // Store the forecast and demand when the sweep reaches this flow.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pred_q[g] <= '0;
                dem_q[g]  <= '0;
            end else if (wr) begin
                pred_q[g] <= pred_new;
                dem_q[g]  <= dem_new;
            end
        end

        assign demand_flat[g*CNT_W +: CNT_W] = dem_q[g];
    end
endmodule

// File: rtl/demand_estimator_chk.sv
// Assertion checker for demand_estimator, attached by bind.
// Observes the ports plus the boundary flag and the sweep position.
module demand_estimator_chk #(
    parameter int N_FLOWS = 4,
    parameter int CNT_W   = 16,
    localparam int FW = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     boundary,
    input logic                     running,
    input logic [FW-1:0]            idx,
    input logic [N_FLOWS*CNT_W-1:0] demand_flat,
    input logic                     sweep_done
);
    // R1: reset clears outputs.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (demand_flat == '0 && !sweep_done));

    // R3: a boundary starts a sweep at flow 0.
    p_boundary_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (running && idx == '0));

    // R7: demands hold while no sweep is running.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(demand_flat));

    // R8: the strobe lasts one clock.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);

    // R8: the strobe follows the write of the last flow.
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> $past(running && idx == FW'(N_FLOWS - 1)));
endmodule

bind demand_estimator demand_estimator_chk #(.N_FLOWS(N_FLOWS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary    (boundary),
    .running     (running),
    .idx         (idx),
    .demand_flat (demand_flat),
    .sweep_done  (sweep_done)
);

// File: tb/tb_demand_estimator.sv
// Bench: behavioural per-clock reference model compared against the outputs.
module tb_demand_estimator;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int T  = 8;
    localparam int FW = 2;
    localparam int MAXV = (1 << W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            slot_en = 1'b0;
    logic            arr_valid = 1'b0;
    logic [FW-1:0]   arr_flow = '0;
    logic [N*W-1:0]  backlog_flat = '0;
    logic [N*W-1:0]  alloc_flat = '0;
    logic [N*W-1:0]  demand_flat;
    logic            sweep_done;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    chk_on = 0;
    bit    ended = 0;
    string cur_req = "R1";

    int m_cnt [N];
    int m_pred[N];
    int m_pend[N];
    int m_dem [N];
    int m_pos;
    int m_slot;
    bit m_done;

    demand_estimator #(.N_FLOWS(N), .CNT_W(W), .PERIOD_SLOTS(T)) dut (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .arr_valid(arr_valid),
        .arr_flow(arr_flow), .backlog_flat(backlog_flat), .alloc_flat(alloc_flat),
        .demand_flat(demand_flat), .sweep_done(sweep_done)
    );

    always #5 clk = ~clk;

    // Reference model: all demands of a period are computed at once, then released one per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cnt[i] = 0; m_pred[i] = 0; m_pend[i] = 0; m_dem[i] = 0;
            end
            m_pos = -1; m_slot = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_pos >= 0) begin
                m_dem[m_pos] = m_pend[m_pos];
                if (m_pos == N - 1) begin m_done = 1; m_pos = -1; end
                else m_pos++;
            end
            if (slot_en && arr_valid) m_cnt[arr_flow]++;
            if (slot_en && m_slot == T - 1) begin
                for (int i = 0; i < N; i++) begin
                    int p, b, d;
                    p = (m_cnt[i] + m_pred[i]) / 2;
                    m_pred[i] = p;
                    b = int'(backlog_flat[i*W +: W]) + m_cnt[i] - int'(alloc_flat[i*W +: W]);
                    if (b < 0) b = 0;
                    d = p + b;
                    if (d > MAXV) d = MAXV;
                    m_pend[i] = d;
                    m_cnt[i] = 0;
                end
                m_pos = 0; m_slot = 0;
            end else if (slot_en) begin
                m_slot++;
            end
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            for (int i = 0; i < N; i++) begin
                n_cmp++;
                if (int'(demand_flat[i*W +: W]) != m_dem[i]) begin
                    n_bad++;
                    $display("FAIL %s flow %0d demand actual %0d expected %0d at cycle %0d",
                             cur_req, i, demand_flat[i*W +: W], m_dem[i], cyc);
                end
            end
            n_cmp++;
            if (sweep_done != m_done) begin
                n_bad++;
                $display("FAIL R8 strobe actual %0b expected %0b at cycle %0d", sweep_done, m_done, cyc);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !ended) begin
            ended = 1;
            n_bad++;
            $display("FAIL watchdog actual %0d cycles expected fewer than 50000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic do_slot(input bit en, input bit v, input int f);
        @(negedge clk);
        slot_en   = en;
        arr_valid = v;
        arr_flow  = FW'(f % N);
    endtask

    task automatic set_flow(input int i, input int bk, input int al);
        backlog_flat[i*W +: W] = W'(bk);
        alloc_flat[i*W +: W]   = W'(al);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held.
        n_cmp++;
        if (demand_flat != '0 || sweep_done != 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset actual %h/%0b expected 0/0", demand_flat, sweep_done);
        end
        rst_n  = 1'b1;
        chk_on = 1;

        // R2: mixed arrivals, with valid cells during disabled slots.
        cur_req = "R2";
        for (int k = 0; k < 80; k++) do_slot(k % 7 != 6, k % 3 != 0, (k * 5) % N);

        // R3: sparse slot enables and arrivals landing on last slots.
        cur_req = "R3";
        for (int k = 0; k < 90; k++) do_slot(k % 3 == 0, 1'b1, k / 3);

        // R4: steady stream on flow 0 to show forecast convergence.
        cur_req = "R4";
        for (int k = 0; k < 12 * T; k++) do_slot(1'b1, k % 4 != 3, 0);
        for (int k = 0; k < 3 * T; k++) do_slot(1'b1, 1'b0, 0);

        // R5: allocations exceed backlog plus arrivals, so the term clamps.
        cur_req = "R5";
        for (int i = 0; i < N; i++) set_flow(i, 3 + i, 40 + i);
        for (int k = 0; k < 4 * T; k++) do_slot(1'b1, 1'b1, k);
        set_flow(1, 50, 10);
        for (int k = 0; k < 3 * T; k++) do_slot(1'b1, k % 2 == 0, 1);

        // R6: full-scale backlog forces saturation.
        cur_req = "R6";
        for (int i = 0; i < N; i++) set_flow(i, MAXV - i, 0);
        for (int k = 0; k < 4 * T; k++) do_slot(1'b1, 1'b1, k);

        // R7: backlog and allocation change every clock; only boundary values count.
        cur_req = "R7";
        for (int k = 0; k < 8 * T; k++) begin
            for (int i = 0; i < N; i++) set_flow(i, (k * 13 + i * 7) % 200, (k * 11 + i * 3) % 150);
            do_slot(k % 5 != 4, k % 2 == 1, k + k / 3);
        end

        cur_req = "R8";
        for (int k = 0; k < 3 * T; k++) do_slot(1'b1, 1'b0, 0);

        @(negedge clk);
        chk_on = 0;
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule